// File: doc/BRIEF.md
# Four-Channel Input Capture Timer

This block timestamps external events. One free-running up-counter, 32 bits wide by default, is shared by four capture channels. When a channel sees a qualifying edge on its trigger, it copies the counter into its own capture register and sets a sticky status bit. Software clears a status bit by writing a one to it. The counter needs no start command. It begins counting as soon as reset is released. Its count-enable comes from one of three places: the bus clock halved, the bus clock quartered, or rising edges on an external clock-bus line.

Each channel picks its trigger from one of two places: its own asynchronous pin, or its own line of a synchronous 4-bit event bus. Each channel also picks which edge of that trigger counts. The status bits are ORed into one interrupt request. Channel 0 also raises a one-cycle DMA request each time it captures. A small read port returns the capture register of the channel that is addressed.

Top module: `capture_timer`

## Requirements
- R1: While `rst_n` is low, `count_val`, `stat`, `irq`, `dma_req` and `ovf_pulse` are 0, and every capture register reads as 0.
- R2: The counter starts counting by itself after reset and only ever steps up by one. With `clk_sel`=0 it steps once every 2 bus clocks.
- R3: With `clk_sel`=1 the counter steps once every 4 bus clocks.
- R4: With `clk_sel`=2 or 3 the counter steps once for each rising edge of `ext_clk_line`, after a two-flop synchronizer. Falling edges and steady levels do not step it.
- R5: Stepping from all-ones wraps the counter to 0 and pulses `ovf_pulse` high for one cycle, on the edge where the counter reads 0.
- R6: A capture stores the counter value held just before the capture clock edge, even when the counter steps on that same edge.
- R7: With `src_sel[i]`=0, channel i triggers from `cap_pin[i]` through a two-flop synchronizer, so capture happens on the third clock edge after the pin changes. With `src_sel[i]`=1, it triggers from `evt_bus[i]` and captures on the next edge. The source that is not selected has no effect on the channel.
- R8: `edge_sel[2i+1:2i]` picks the active edge for channel i: 0 is rising, 1 is falling, 2 and 3 are both. A wrong-direction edge captures nothing.
- R9: A capture on channel i sets `stat[i]`. `irq` is high exactly while any bit of `stat` is set.
- R10: A one on `clr_stat[i]` clears `stat[i]` on the next edge. If a capture happens on channel i in that same cycle, the bit stays set.
- R11: `dma_req` pulses for one cycle with each channel 0 capture, in the same cycle that `stat[0]` sets. Captures on other channels do not raise it.
- R12: `rd_data` shows the capture register of channel `rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 2 | Count source: 0 clock/2, 1 clock/4, 2 or 3 external line |
| ext_clk_line | input | 1 | External clock-bus line (asynchronous) |
| cap_pin | input | 4 | Per-channel trigger pins (asynchronous) |
| evt_bus | input | 4 | Synchronous input event bus, one line per channel |
| src_sel | input | 4 | Per-channel trigger source: 0 pin, 1 event line |
| edge_sel | input | 8 | Two bits per channel: 0 rise, 1 fall, 2/3 both |
| clr_stat | input | 4 | Write-one-to-clear strobes for the status bits |
| rd_sel | input | 2 | Channel addressed by the read port |
| rd_data | output | 32 | Capture register of the addressed channel |
| count_val | output | 32 | Current counter value |
| stat | output | 4 | Sticky per-channel capture flags |
| irq | output | 1 | Shared interrupt request |
| dma_req | output | 1 | One-cycle DMA request on a channel 0 capture |
| ovf_pulse | output | 1 | One-cycle pulse when the counter wraps |

## Verification
The assertions check on every cycle that:
- the counter only ever moves by one step;
- a wrap pulse coincides with a zero count;
- a DMA request never appears without its status bit;
- status bits and the interrupt fall only after a clear strobe.

Other behaviour can only be shown by the bench's scenarios:
- the rates of the three count sources;
- the exact value a capture latches when the counter steps on the capture edge;
- the pin and event-bus latencies;
- edge-direction filtering;
- the rule that the source not selected is ignored.

// File: rtl/ct_pkg.sv
// Package: shared encodings for the capture timer.
// Assumes: consumers import it before declaring ports that use these types.
package ct_pkg;
    typedef enum logic [1:0] {
        CLK_DIV2 = 2'd0,
        CLK_DIV4 = 2'd1,
        CLK_EXT  = 2'd2,
        CLK_EXT2 = 2'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        EDGE_RISE  = 2'd0,
        EDGE_FALL  = 2'd1,
        EDGE_BOTH  = 2'd2,
        EDGE_BOTH2 = 2'd3
    } edge_mode_e;
endpackage

// File: rtl/ct_tick_gen.sv
// Module: ct_tick_gen
// Produces a single-cycle count-enable pulse in the bus clock domain.
// The pulse comes from a free-running prescaler (divide by 2 or by 4) or from
// synchronized rising edges of an asynchronous external clock line.
// Assumes: the external line is slower than half the bus clock.
module ct_tick_gen
    import ct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  clk_src_e   src,
    input  logic       ext_line,
    output logic       tick
);
    logic [1:0]             pre_q;
    logic [SYNC_STAGES-1:0] ext_sync_q;
    logic                   ext_prev_q;
    logic                   ext_rise;

    // Free-running prescaler, starts counting right after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 2'd1;
    end

    // Synchronizer chain and previous-level register for the external line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_sync_q <= '0;
            ext_prev_q <= 1'b0;
        end else begin
            ext_sync_q <= {ext_sync_q[SYNC_STAGES-2:0], ext_line};
            ext_prev_q <= ext_sync_q[SYNC_STAGES-1];
        end
    end

    assign ext_rise = ext_sync_q[SYNC_STAGES-1] & ~ext_prev_q;

    // Choose which enable source drives the counter.
    always_comb begin
        unique case (src)
            CLK_DIV2: tick = pre_q[0];
            CLK_DIV4: tick = &pre_q;
            default:  tick = ext_rise;
        endcase
    end
endmodule

// File: rtl/ct_capture_chan.sv
// Module: ct_capture_chan
// One capture channel. It selects pin or event-bus trigger, detects the
// chosen edge, latches the shared count and keeps a sticky write-one-to-clear
// status bit.
// Assumes: evt is synchronous to clk. The pin is asynchronous and is synchronized here.
module ct_capture_chan
    import ct_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic             evt,
    input  logic             use_evt,
    input  edge_mode_e       mode,
    input  logic             clr,
    input  logic [CNT_W-1:0] count,
    output logic             cap_ev,
    output logic             stat,
    output logic [CNT_W-1:0] cap_val
);
    logic [SYNC_STAGES-1:0] pin_sync_q;
    logic                   trig;
    logic                   trig_prev_q;
    logic                   rise;
    logic                   fall;

    // Two-flop synchronizer for the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_sync_q <= '0;
        else        pin_sync_q <= {pin_sync_q[SYNC_STAGES-2:0], pin};
    end

    assign trig = use_evt ? evt : pin_sync_q[SYNC_STAGES-1];

    // Remember the trigger level of the previous cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_prev_q <= 1'b0;
        else        trig_prev_q <= trig;
    end

    assign rise = trig & ~trig_prev_q;
    assign fall = ~trig & trig_prev_q;

    // Qualify the detected edge against the selected mode.
    always_comb begin
        unique case (mode)
            EDGE_RISE: cap_ev = rise;
            EDGE_FALL: cap_ev = fall;
            default:   cap_ev = rise | fall;
        endcase
    end

    // Latch the count as it stands before this edge's increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_val <= '0;
        else if (cap_ev) cap_val <= count;
    end

    // Sticky status: a capture wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= 1'b0;
        else        stat <= (stat & ~clr) | cap_ev;
    end
endmodule

// File: rtl/capture_timer.sv
// Module: capture_timer (top)
// Free-running shared up-counter with N_CH capture channels, a shared
// interrupt, a DMA request from one channel and a read port for the captures.
// Assumes: rst_n is synchronous to clk. Counting begins at reset release.
module capture_timer
    import ct_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int N_CH   = 4,
    parameter int DMA_CH = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              clk_sel,
    input  logic                    ext_clk_line,
    input  logic [N_CH-1:0]         cap_pin,
    input  logic [N_CH-1:0]         evt_bus,
    input  logic [N_CH-1:0]         src_sel,
    input  logic [2*N_CH-1:0]       edge_sel,
    input  logic [N_CH-1:0]         clr_stat,
    input  logic [$clog2(N_CH)-1:0] rd_sel,
    output logic [CNT_W-1:0]        rd_data,
    output logic [CNT_W-1:0]        count_val,
    output logic [N_CH-1:0]         stat,
    output logic                    irq,
    output logic                    dma_req,
    output logic                    ovf_pulse
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic                  tick;
    logic [CNT_W-1:0]      cnt_q;
    logic [N_CH-1:0]       cap_ev;
    logic [CNT_W-1:0]      cap_val [N_CH];

    ct_tick_gen #(.SYNC_STAGES(2)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (clk_src_e'(clk_sel)),
        .ext_line (ext_clk_line),
        .tick     (tick)
    );

    // Shared counter: step on each enable pulse, wrap at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + CNT_W'(tick);
    end

    // Overflow pulse, aligned with the counter reading zero.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_pulse <= 1'b0;
        else        ovf_pulse <= tick && (cnt_q == CNT_MAX);
    end

    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_ch
            ct_capture_chan #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .pin     (cap_pin[i]),
                .evt     (evt_bus[i]),
                .use_evt (src_sel[i]),
                .mode    (edge_mode_e'(edge_sel[2*i +: 2])),
                .clr     (clr_stat[i]),
                .count   (cnt_q),
                .cap_ev  (cap_ev[i]),
                .stat    (stat[i]),
                .cap_val (cap_val[i])
            );
        end
    endgenerate

    // DMA request follows the designated channel's capture by one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) dma_req <= 1'b0;
        else        dma_req <= cap_ev[DMA_CH];
    end

    assign count_val = cnt_q;
    assign irq       = |stat;
    assign rd_data   = cap_val[rd_sel];
endmodule

// File: rtl/ct_checker.sv
// Module: ct_checker
// Concurrent checks on the capture timer ports. It is attached with bind.
// Assumes: it is clocked by the same clk and reset as the timer.
module ct_checker #(
    parameter int CNT_W  = 32,
    parameter int N_CH   = 4,
    parameter int DMA_CH = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count_val,
    input logic [N_CH-1:0]  stat,
    input logic [N_CH-1:0]  clr_stat,
    input logic             irq,
    input logic             dma_req,
    input logic             ovf_pulse
);
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count_val != $past(count_val)) |-> (count_val == CNT_W'($past(count_val) + 1'b1)));

    assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (count_val == '0));

    assert_irq_needs_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> ($past(clr_stat) != '0));

    assert_stat_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat) & ~stat & ~$past(clr_stat)) == '0));

    assert_dma_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> stat[DMA_CH]);
endmodule

bind capture_timer ct_checker #(.CNT_W(CNT_W), .N_CH(N_CH), .DMA_CH(DMA_CH)) u_ct_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_val (count_val),
    .stat      (stat),
    .clr_stat  (clr_stat),
    .irq       (irq),
    .dma_req   (dma_req),
    .ovf_pulse (ovf_pulse)
);

// File: tb/capture_timer_bench.sv
module capture_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  clk_sel = 2'd0;
    logic        ext_clk_line = 1'b0;
    logic [3:0]  cap_pin = '0;
    logic [3:0]  evt_bus = '0;
    logic [3:0]  src_sel = '0;
    logic [7:0]  edge_sel = '0;
    logic [3:0]  clr_stat = '0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_data, count_val;
    logic [3:0]  stat;
    logic        irq, dma_req, ovf_pulse;
    logic [7:0]  s_rd, s_cnt;
    logic [3:0]  s_stat;
    logic        s_irq, s_dma, s_ovf;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    capture_timer u_capture_timer (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_clk_line(ext_clk_line),
        .cap_pin(cap_pin), .evt_bus(evt_bus), .src_sel(src_sel), .edge_sel(edge_sel),
        .clr_stat(clr_stat), .rd_sel(rd_sel), .rd_data(rd_data), .count_val(count_val),
        .stat(stat), .irq(irq), .dma_req(dma_req), .ovf_pulse(ovf_pulse)
    );

    capture_timer #(.CNT_W(8)) u_capture_timer_w8 (
        .clk(clk), .rst_n(rst_n), .clk_sel(2'd0), .ext_clk_line(1'b0),
        .cap_pin(4'd0), .evt_bus(4'd0), .src_sel(4'd0), .edge_sel(8'd0),
        .clr_stat(4'd0), .rd_sel(2'd0), .rd_data(s_rd), .count_val(s_cnt),
        .stat(s_stat), .irq(s_irq), .dma_req(s_dma), .ovf_pulse(s_ovf)
    );

    typedef struct packed {
        logic [1:0] ch;
        logic       src;
        logic [1:0] mode;
        logic       lvl0;
        logic       lvl1;
        logic       other;
        logic       hit;
    } vec_t;

    // channel, source, edge mode, start level, end level, drive other source, expect capture
    localparam vec_t VEC [12] = '{
        '{2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{2'd1, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{2'd2, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1},
        '{2'd3, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1},
        '{2'd0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1},
        '{2'd1, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1},
        '{2'd2, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{2'd3, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{2'd0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{2'd1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{2'd2, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1},
        '{2'd3, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1}
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        clr_stat = 4'hF;
        @(negedge clk);
        clr_stat = 4'h0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] c0, exp, pre;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(count_val == 0 && stat == 0 && !irq && !dma_req && !ovf_pulse, "R1",
              {count_val, stat}, 0);
        for (int k = 0; k < 4; k++) begin
            rd_sel = 2'(k);
            #0.1;
            check(rd_data == 0, "R1", rd_data, 0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2: divide by two, starts without any command
        repeat (3) @(negedge clk);
        c0 = count_val;
        repeat (10) @(negedge clk);
        check(count_val == c0 + 5, "R2", count_val, c0 + 5);

        // R3: divide by four
        clk_sel = 2'd1;
        repeat (2) @(negedge clk);
        c0 = count_val;
        repeat (20) @(negedge clk);
        check(count_val == c0 + 5, "R3", count_val, c0 + 5);

        // R4: external line, rising edges only
        clk_sel = 2'd2;
        repeat (6) @(negedge clk);
        c0 = count_val;
        for (int p = 0; p < 3; p++) begin
            ext_clk_line = 1'b1;
            repeat (4) @(negedge clk);
            ext_clk_line = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check(count_val == c0 + 3, "R4", count_val, c0 + 3);
        clk_sel = 2'd3;
        ext_clk_line = 1'b1;
        repeat (12) @(negedge clk);
        check(count_val == c0 + 4, "R4", count_val, c0 + 4);
        ext_clk_line = 1'b0;
        repeat (6) @(negedge clk);
        check(count_val == c0 + 4, "R4", count_val, c0 + 4);

        // Table of capture scenarios (R6, R7, R8, R9, R12); divide by two keeps steps on capture edges
        clk_sel = 2'd0;
        foreach (VEC[v]) begin
            src_sel[VEC[v].ch] = VEC[v].src;
            edge_sel[2*VEC[v].ch +: 2] = VEC[v].mode;
            cap_pin[VEC[v].ch] = VEC[v].lvl0;
            evt_bus[VEC[v].ch] = VEC[v].lvl0;
            rd_sel = VEC[v].ch;
            repeat (6) @(negedge clk);
            clear_all();
            pre = rd_data;
            if (VEC[v].src ^ VEC[v].other) evt_bus[VEC[v].ch] = VEC[v].lvl1;
            else                           cap_pin[VEC[v].ch] = VEC[v].lvl1;
            if (!VEC[v].src) repeat (2) @(negedge clk);
            exp = count_val;
            @(negedge clk);
            if (VEC[v].hit) begin
                check(stat == (4'b1 << VEC[v].ch), "R9", stat, 4'b1 << VEC[v].ch);
                check(irq == 1'b1, "R9", irq, 1);
                check(rd_data == exp, "R6 R7 R12", rd_data, exp);
            end else begin
                check(stat == 4'b0, "R7 R8", stat, 0);
                check(irq == 1'b0, "R9", irq, 0);
                check(rd_data == pre, "R7 R8", rd_data, pre);
            end
            repeat (4) @(negedge clk);
        end

        // R10: clear alone, and clear colliding with a capture
        src_sel = 4'hF;
        edge_sel = 8'h00;
        evt_bus = 4'h0;
        cap_pin = 4'h0;
        repeat (4) @(negedge clk);
        clear_all();
        evt_bus[1] = 1'b1;
        @(negedge clk);
        evt_bus[1] = 1'b0;
        @(negedge clk);
        check(stat == 4'b0010, "R10", stat, 4'b0010);
        evt_bus[1] = 1'b1;
        clr_stat = 4'b0010;
        @(negedge clk);
        clr_stat = 4'b0;
        check(stat[1] == 1'b1, "R10", stat[1], 1);
        clr_stat = 4'b0010;
        @(negedge clk);
        clr_stat = 4'b0;
        check(stat == 4'b0 && !irq, "R10", stat, 0);

        // R11: DMA request on channel 0 only
        evt_bus[2] = 1'b1;
        @(negedge clk);
        check(dma_req == 1'b0, "R11", dma_req, 0);
        evt_bus[0] = 1'b1;
        @(negedge clk);
        check(dma_req == 1'b1 && stat[0], "R11", dma_req, 1);
        @(negedge clk);
        check(dma_req == 1'b0, "R11", dma_req, 0);

        // R5: wrap of the narrow instance
        while (s_cnt != 8'hFF) @(negedge clk);
        while (s_cnt == 8'hFF) begin
            check(s_ovf == 1'b0, "R5", s_ovf, 0);
            @(negedge clk);
        end
        check(s_cnt == 8'h00 && s_ovf == 1'b1, "R5", {s_cnt, s_ovf}, 1);
        @(negedge clk);
        check(s_ovf == 1'b0, "R5", s_ovf, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule